// File: doc/BRIEF.md
# USB IN Endpoint Packet Buffer

This block controls the transmit side of a single device-side IN endpoint. The CPU loads packet bytes through a byte write port. Each packet is then committed for transmission, either by a manual ready strobe or automatically once the packet reaches the programmed maximum size. The USB engine pulls committed packets from the other side. It reads the length at the head of the queue, fetches exactly that many bytes, and signals completion. The block keeps the ready flag, the FIFO-not-empty flag, a sticky overrun error and a sticky interrupt flag, and emits a one-cycle interrupt pulse.

The endpoint runs in one of two modes. In single-packet mode one committed packet may wait in the buffer. Double-packet mode allows two, but only when the double-buffer disable bit has been cleared and twice the maximum packet size fits in the buffer. In double-packet mode the ready flag has a different meaning: committing into an empty queue drops it again at once and raises an interrupt, so software may load a second packet. Software then uses FIFO-not-empty to tell whether one slot or two are free.

Top module: `inEpPktBuf`

## Requirements
- R1: After reset, ready, fifoNotEmpty, overrun, intFlag, intPulse and dblActive are 0, dblDis is 1 and maxPkt equals the MAX_RST parameter.
- R2: With autoSet high, the packet commits on its own in the cycle after the byte that brings the loaded count to maxPkt. A shorter packet commits only when setReady is pulsed.
- R3: In single-packet mode a commit sets ready and fifoNotEmpty. A pktDone then clears both, pulses intPulse for exactly one cycle and sets intFlag.
- R4: A data write is dropped and sets the sticky overrun bit when every allowed slot is committed (one in single mode, two in double mode). ovrClr clears overrun.
- R5: dblActive is 1 exactly when dblDis is 0 and 2*maxPkt is at most FIFO_BYTES. Otherwise the endpoint holds one packet.
- R6: In double-packet mode, a commit into an empty queue leaves ready at 0, sets fifoNotEmpty and pulses intPulse. A commit while one packet is queued sets ready.
- R7: In double-packet mode each pktDone clears ready and pulses intPulse. fifoNotEmpty is then 1 if one packet remains and 0 if none remains.
- R8: pktLen shows the byte count of the oldest committed packet. rdData shows its bytes in load order, one per rdEn, and packets leave in commit order.
- R9: Writes to maxPkt (through cfgMaxWe) and to dblDis (through cfgDisWe) are ignored while any byte is loaded or queued. A maxPkt value of 0 or above FIFO_BYTES is always ignored.
- R10: intFlag stays set until intClr is pulsed. An interrupt event in the same cycle as intClr leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, flushes all state |
| cfgMaxWe | input | 1 | Write strobe for the maximum packet size |
| cfgMaxVal | input | LEN_W | New maximum packet size in bytes |
| cfgDisWe | input | 1 | Write strobe for the double-buffer disable bit |
| cfgDisVal | input | 1 | New value of the disable bit |
| autoSet | input | 1 | Commit automatically on a full-size packet |
| wrValid | input | 1 | CPU byte write strobe |
| wrData | input | DATA_W | CPU byte |
| setReady | input | 1 | Manual commit of the packet being loaded |
| intClr | input | 1 | Clears intFlag (write-1-to-clear) |
| ovrClr | input | 1 | Clears overrun |
| rdEn | input | 1 | USB side consumes one byte |
| pktDone | input | 1 | USB side reports the head packet sent |
| ready | output | 1 | Ready status flag |
| fifoNotEmpty | output | 1 | At least one committed packet queued |
| dblActive | output | 1 | Endpoint currently runs double-packet mode |
| maxPkt | output | LEN_W | Current maximum packet size |
| dblDis | output | 1 | Current double-buffer disable bit |
| overrun | output | 1 | Sticky dropped-write error |
| intFlag | output | 1 | Sticky endpoint interrupt status |
| intPulse | output | 1 | One-cycle endpoint interrupt |
| pktAvail | output | 1 | A committed packet is available to the USB side |
| pktLen | output | LEN_W | Byte count of the head packet |
| rdData | output | DATA_W | Current byte of the head packet |

## Verification
All status flags are registered. A byte write, a commit, a config write or a pktDone shows up on the outputs one clock edge after the cycle in which it was driven. intPulse is high for exactly that one following cycle and low again after the next edge. pktLen and rdData are combinational from registered pointers, so they are valid in the cycle after a commit or a read strobe. The bench drives each input shortly after a rising edge and samples shortly after the next rising edge. Each sample therefore falls in the first cycle in which the result is due, and the intPulse checks also look at the cycle after that.

// File: rtl/inEpPkg.sv
package inEpPkg;
  // Strobes from the control unit to the byte datapath.
  typedef struct packed {
    logic wrByte;   // store wrData at the write pointer
    logic rdByte;   // advance the read pointer by one
    logic rdSkip;   // head packet finished: skip its unread bytes
  } dpStrb_t;
endpackage

// File: rtl/inEpData.sv
module inEpData
  import inEpPkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [LEN_W-1:0]  skipCnt,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int PW = $clog2(FIFO_BYTES);

  logic [DATA_W-1:0] mem [FIFO_BYTES];
  logic [PW-1:0]     wrPtr;
  logic [PW-1:0]     rdPtr;

  always_ff @(posedge clk) begin
    if (strb.wrByte) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrByte) wrPtr <= wrPtr + PW'(1);
      if (strb.rdSkip)      rdPtr <= rdPtr + PW'(skipCnt);
      else if (strb.rdByte) rdPtr <= rdPtr + PW'(1);
    end
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/inEpCtrl.sv
module inEpCtrl
  import inEpPkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int MAX_RST    = 8,
  parameter int LEN_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaxWe,
  input  logic [LEN_W-1:0] cfgMaxVal,
  input  logic             cfgDisWe,
  input  logic             cfgDisVal,
  input  logic             autoSet,
  input  logic             wrValid,
  input  logic             setReady,
  input  logic             intClr,
  input  logic             ovrClr,
  input  logic             rdEn,
  input  logic             pktDone,
  output logic             ready,
  output logic             fifoNotEmpty,
  output logic             dblActive,
  output logic [LEN_W-1:0] maxPkt,
  output logic             dblDis,
  output logic             overrun,
  output logic             intFlag,
  output logic             intPulse,
  output logic             pktAvail,
  output logic [LEN_W-1:0] pktLen,
  output dpStrb_t          strb,
  output logic [LEN_W-1:0] skipCnt
);
  logic [LEN_W-1:0] lenQ [2];
  logic             headIdx;
  logic [1:0]       count;
  logic [LEN_W-1:0] loadCnt;
  logic [LEN_W-1:0] sentCnt;

  logic [LEN_W:0]   twiceMax;
  logic             dblMode;
  logic [1:0]       cap;
  logic             slotFree, idle, wrAcc, wrDrop, autoHit, commit, done;
  logic             rdAcc, effEmpty, intEvt, tailIdx;
  logic [LEN_W-1:0] headLen, commitLen;

  assign twiceMax  = {maxPkt, 1'b0};
  assign dblMode   = !dblDis && (twiceMax <= (LEN_W+1)'(FIFO_BYTES));
  assign cap       = dblMode ? 2'd2 : 2'd1;
  assign slotFree  = count < cap;
  assign idle      = (count == 2'd0) && (loadCnt == '0);
  assign headLen   = lenQ[headIdx];
  assign tailIdx   = headIdx ^ count[0];

  assign wrAcc     = wrValid && slotFree && (loadCnt < maxPkt);
  assign wrDrop    = wrValid && !wrAcc;
  assign commitLen = loadCnt + LEN_W'(wrAcc);
  assign autoHit   = autoSet && wrAcc && ((loadCnt + LEN_W'(1)) == maxPkt);
  assign commit    = slotFree && (setReady || autoHit);
  assign done      = pktDone && (count != 2'd0);
  assign rdAcc     = rdEn && (count != 2'd0) && (sentCnt < headLen);
  assign effEmpty  = (count == 2'd0) || ((count == 2'd1) && done);
  assign intEvt    = done || (commit && dblMode && effEmpty);

  always_comb begin
    strb.wrByte = wrAcc;
    strb.rdByte = rdAcc;
    strb.rdSkip = done;
  end
  assign skipCnt = headLen - sentCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ[0]  <= '0;
      lenQ[1]  <= '0;
      headIdx  <= 1'b0;
      count    <= 2'd0;
      loadCnt  <= '0;
      sentCnt  <= '0;
      ready    <= 1'b0;
      overrun  <= 1'b0;
      intFlag  <= 1'b0;
      intPulse <= 1'b0;
      maxPkt   <= LEN_W'(MAX_RST);
      dblDis   <= 1'b1;
    end else begin
      count <= count + {1'b0, commit} - {1'b0, done};
      if (done)   headIdx <= ~headIdx;
      if (commit) lenQ[tailIdx] <= commitLen;

      if (commit)     loadCnt <= '0;
      else if (wrAcc) loadCnt <= loadCnt + LEN_W'(1);

      if (done)       sentCnt <= '0;
      else if (rdAcc) sentCnt <= sentCnt + LEN_W'(1);

      if (commit)    ready <= !(dblMode && effEmpty);
      else if (done) ready <= 1'b0;

      if (wrDrop)      overrun <= 1'b1;
      else if (ovrClr) overrun <= 1'b0;

      intPulse <= intEvt;
      if (intEvt)      intFlag <= 1'b1;
      else if (intClr) intFlag <= 1'b0;

      if (cfgMaxWe && idle && (cfgMaxVal != '0) &&
          (cfgMaxVal <= LEN_W'(FIFO_BYTES)))
        maxPkt <= cfgMaxVal;
      if (cfgDisWe && idle) dblDis <= cfgDisVal;
    end
  end

  assign fifoNotEmpty = (count != 2'd0);
  assign pktAvail     = (count != 2'd0);
  assign pktLen       = headLen;
  assign dblActive    = dblMode;

  // R3
  single_commit_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !dblMode) |=> (ready && fifoNotEmpty));

  // R3
  done_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && fifoNotEmpty) |=> intPulse);

  // R4
  drop_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !slotFree) |=> overrun);

  // R6
  first_commit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commit && dblMode && count == 2'd0) |=> (!ready && intPulse && fifoNotEmpty));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> ($stable(maxPkt) && $stable(dblDis)));

  // R10
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |-> intFlag);

  // R3
  ready_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> fifoNotEmpty);
endmodule

// File: rtl/inEpPktBuf.sv
module inEpPktBuf
  import inEpPkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int DATA_W     = 8,
  parameter int MAX_RST    = 8,
  parameter int LEN_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMaxWe,
  input  logic [LEN_W-1:0]  cfgMaxVal,
  input  logic              cfgDisWe,
  input  logic              cfgDisVal,
  input  logic              autoSet,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              setReady,
  input  logic              intClr,
  input  logic              ovrClr,
  input  logic              rdEn,
  input  logic              pktDone,
  output logic              ready,
  output logic              fifoNotEmpty,
  output logic              dblActive,
  output logic [LEN_W-1:0]  maxPkt,
  output logic              dblDis,
  output logic              overrun,
  output logic              intFlag,
  output logic              intPulse,
  output logic              pktAvail,
  output logic [LEN_W-1:0]  pktLen,
  output logic [DATA_W-1:0] rdData
);
  dpStrb_t          strb;
  logic [LEN_W-1:0] skipCnt;

  inEpCtrl #(.FIFO_BYTES(FIFO_BYTES), .MAX_RST(MAX_RST), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgMaxWe(cfgMaxWe), .cfgMaxVal(cfgMaxVal),
    .cfgDisWe(cfgDisWe), .cfgDisVal(cfgDisVal),
    .autoSet(autoSet), .wrValid(wrValid), .setReady(setReady),
    .intClr(intClr), .ovrClr(ovrClr), .rdEn(rdEn), .pktDone(pktDone),
    .ready(ready), .fifoNotEmpty(fifoNotEmpty), .dblActive(dblActive),
    .maxPkt(maxPkt), .dblDis(dblDis), .overrun(overrun),
    .intFlag(intFlag), .intPulse(intPulse),
    .pktAvail(pktAvail), .pktLen(pktLen),
    .strb(strb), .skipCnt(skipCnt)
  );

  inEpData #(.FIFO_BYTES(FIFO_BYTES), .DATA_W(DATA_W), .LEN_W(LEN_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .skipCnt(skipCnt),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/inEpPktBuf_test.sv
`timescale 1ns/1ps
module inEpPktBuf_test;
  localparam int FIFO_BYTES = 64;
  localparam int DATA_W     = 8;
  localparam int MAX_RST    = 8;
  localparam int LEN_W      = $clog2(FIFO_BYTES + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMaxWe = 0, cfgDisWe = 0, cfgDisVal = 0, autoSet = 0;
  logic [LEN_W-1:0] cfgMaxVal = '0;
  logic wrValid = 0, setReady = 0, intClr = 0, ovrClr = 0, rdEn = 0, pktDone = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic ready, fifoNotEmpty, dblActive, dblDis, overrun, intFlag, intPulse, pktAvail;
  logic [LEN_W-1:0] maxPkt, pktLen;
  logic [DATA_W-1:0] rdData;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  inEpPktBuf #(.FIFO_BYTES(FIFO_BYTES), .DATA_W(DATA_W), .MAX_RST(MAX_RST)) uut (
    .clk(clk), .rstN(rstN), .cfgMaxWe(cfgMaxWe), .cfgMaxVal(cfgMaxVal),
    .cfgDisWe(cfgDisWe), .cfgDisVal(cfgDisVal), .autoSet(autoSet),
    .wrValid(wrValid), .wrData(wrData), .setReady(setReady),
    .intClr(intClr), .ovrClr(ovrClr), .rdEn(rdEn), .pktDone(pktDone),
    .ready(ready), .fifoNotEmpty(fifoNotEmpty), .dblActive(dblActive),
    .maxPkt(maxPkt), .dblDis(dblDis), .overrun(overrun),
    .intFlag(intFlag), .intPulse(intPulse), .pktAvail(pktAvail),
    .pktLen(pktLen), .rdData(rdData)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic loadBytes(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      wrValid = 1'b1;
      wrData  = DATA_W'(base + i);
      tick();
    end
    wrValid = 1'b0;
  endtask

  task automatic pulseReady();
    setReady = 1'b1; tick(); setReady = 1'b0;
  endtask

  task automatic writeMax(input int v);
    cfgMaxWe = 1'b1; cfgMaxVal = LEN_W'(v); tick(); cfgMaxWe = 1'b0;
  endtask

  task automatic writeDis(input logic v);
    cfgDisWe = 1'b1; cfgDisVal = v; tick(); cfgDisWe = 1'b0;
  endtask

  task automatic clearInt();
    intClr = 1'b1; tick(); intClr = 1'b0;
  endtask

  // Reads one packet and checks its length and bytes (R8).
  task automatic readPkt(input int base, input int n);
    chk("R8", "pktAvail", int'(pktAvail), 1);
    chk("R8", "pktLen", int'(pktLen), n);
    for (int i = 0; i < n; i++) begin
      chk("R8", "rdData", int'(rdData), (base + i) % 256);
      rdEn = 1'b1; tick(); rdEn = 1'b0;
    end
  endtask

  task automatic sendDone();
    pktDone = 1'b1; tick(); pktDone = 1'b0;
  endtask

  task automatic tReset();
    chk("R1", "ready", int'(ready), 0);
    chk("R1", "fifoNotEmpty", int'(fifoNotEmpty), 0);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "intFlag", int'(intFlag), 0);
    chk("R1", "intPulse", int'(intPulse), 0);
    chk("R1", "dblActive", int'(dblActive), 0);
    chk("R1", "dblDis", int'(dblDis), 1);
    chk("R1", "maxPkt", int'(maxPkt), MAX_RST);
  endtask

  task automatic tSingleAuto();
    autoSet = 1'b1;
    loadBytes(8'h10, MAX_RST - 1);
    chk("R2", "ready before last byte", int'(ready), 0);
    loadBytes(8'h10 + MAX_RST - 1, 1);
    chk("R2", "auto ready", int'(ready), 1);
    chk("R3", "fifoNotEmpty after commit", int'(fifoNotEmpty), 1);
    loadBytes(8'hEE, 1);
    chk("R4", "overrun single committed", int'(overrun), 1);
    ovrClr = 1'b1; tick(); ovrClr = 1'b0;
    chk("R4", "overrun cleared", int'(overrun), 0);
    readPkt(8'h10, MAX_RST);
    sendDone();
    chk("R3", "intPulse after done", int'(intPulse), 1);
    chk("R3", "ready after done", int'(ready), 0);
    chk("R3", "fifoNotEmpty after done", int'(fifoNotEmpty), 0);
    chk("R3", "intFlag after done", int'(intFlag), 1);
    tick();
    chk("R3", "intPulse one cycle", int'(intPulse), 0);
    chk("R10", "intFlag sticky", int'(intFlag), 1);
    clearInt();
    chk("R10", "intFlag cleared", int'(intFlag), 0);
  endtask

  task automatic tSingleShort();
    autoSet = 1'b1;
    loadBytes(8'h40, 3);
    tick();
    chk("R2", "short packet not auto", int'(ready), 0);
    pulseReady();
    chk("R2", "manual ready", int'(ready), 1);
    readPkt(8'h40, 3);
    sendDone();
    chk("R3", "ready clear short", int'(ready), 0);
    clearInt();
  endtask

  task automatic tConfig();
    autoSet = 1'b0;
    loadBytes(8'h60, 1);
    writeMax(16);
    chk("R9", "maxPkt held while loading", int'(maxPkt), MAX_RST);
    writeDis(1'b0);
    chk("R9", "dblDis held while loading", int'(dblDis), 1);
    pulseReady();
    readPkt(8'h60, 1);
    sendDone();
    clearInt();
    writeMax(0);
    chk("R9", "maxPkt zero ignored", int'(maxPkt), MAX_RST);
    writeMax(FIFO_BYTES + 1);
    chk("R9", "maxPkt too big ignored", int'(maxPkt), MAX_RST);
    writeMax(FIFO_BYTES);
    chk("R9", "maxPkt accepted", int'(maxPkt), FIFO_BYTES);
    writeDis(1'b0);
    chk("R9", "dblDis accepted", int'(dblDis), 0);
    chk("R5", "single when 2*max > fifo", int'(dblActive), 0);
    writeMax(FIFO_BYTES / 2);
    chk("R5", "double when it fits", int'(dblActive), 1);
    writeDis(1'b1);
    chk("R5", "disable bit forces single", int'(dblActive), 0);
    writeDis(1'b0);
    writeMax(4);
    chk("R5", "double with max 4", int'(dblActive), 1);
  endtask

  task automatic tDouble();
    autoSet = 1'b1;
    loadBytes(8'h80, 4);
    chk("R6", "ready drops on first commit", int'(ready), 0);
    chk("R6", "fifoNotEmpty first commit", int'(fifoNotEmpty), 1);
    chk("R6", "intPulse first commit", int'(intPulse), 1);
    clearInt();
    loadBytes(8'hA0, 2);
    pulseReady();
    chk("R6", "ready on second commit", int'(ready), 1);
    loadBytes(8'hFF, 1);
    chk("R4", "overrun double full", int'(overrun), 1);
    readPkt(8'h80, 4);
    sendDone();
    chk("R7", "ready after first send", int'(ready), 0);
    chk("R7", "fifoNotEmpty one left", int'(fifoNotEmpty), 1);
    chk("R7", "intPulse first send", int'(intPulse), 1);
    clearInt();
    readPkt(8'hA0, 2);
    pktDone = 1'b1; intClr = 1'b1; tick(); pktDone = 1'b0; intClr = 1'b0;
    chk("R7", "fifoNotEmpty none left", int'(fifoNotEmpty), 0);
    chk("R7", "intPulse second send", int'(intPulse), 1);
    chk("R10", "set wins over clear", int'(intFlag), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    tReset();
    tSingleAuto();
    tSingleShort();
    tConfig();
    tDouble();
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule